// File: doc/BRIEF.md
# VLIW Issue Stage and Floating-Point Register File

This block is the issue and register stage of a four-slot VLIW core that iterates a complex-valued recurrence. Each step it takes one 121-bit instruction word. The word carries four independently enabled slots: an immediate load, a negate, an add and a multiply. The block reads the source registers named by the word and drives the operands to external negate, add and multiply units. At the end of the step it writes the immediate and the unit results back into a 1024-entry file of 27-bit floating-point values.

A step lasts a fixed number of clock cycles (parameter `HOLD`, default 4). This gives registered arithmetic units time to settle before write-back. Registers 0 and 1 hold the real and imaginary parts of the iterated value Z and are always visible on outputs. Register 2 is the escape register. Any write to it of a non-negative value above a programmable limit raises a sticky `done` flag. The surrounding sequencer uses `step_sync_o` to know when the next word is sampled.

Top module: `vliw_issue_rf`

## Requirements
- R1: A step lasts HOLD cycles. `step_sync_o` is high in the first cycle of each step and low in the others. The instruction word is sampled at the rising edge that ends that first cycle, and later changes to `instr_i` within the step have no effect.
- R2: The load slot uses bit 120 as its enable, bits 119:93 as the 27-bit immediate and bits 92:83 as the destination. When enabled, it writes the immediate to the destination.
- R3: Negate uses enable bit 82, source 81:72 and destination 71:62. Add uses enable bit 61, sources 60:51 and 50:41 and destination 40:31. Multiply uses enable bit 30, sources 29:20 and 19:10 and destination 9:0. From the third cycle of a step, each `*_go_o` equals its slot enable and each operand output carries the contents of its source register.
- R4: A slot whose enable bit is clear writes no register, whatever its other fields hold, so an all-zero word changes nothing.
- R5: All operand reads of a step see the register contents from before that step's write-back, even when a slot of the same step writes that register.
- R6: The result inputs are sampled at the rising edge that ends the step and are written to the slot destinations. With HOLD=4, a unit with one register stage of latency is supported.
- R7: `z_re_o` and `z_im_o` always show registers 0 and 1, which keep their values across steps until written.
- R8: `done_o` is set when a write-back writes register 2 with a value whose bit 26 (sign) is 0 and whose bits 25:0, read as an unsigned integer, exceed `esc_limit_i`. Negative values, values equal to the limit and writes to other registers do not set it.
- R9: `done_o` stays high until reset. A synchronous reset clears `done_o` and the go flags and restarts the step at its first cycle, but it leaves the register contents unchanged.
- R10: When all four slots are enabled with distinct destinations, all four writes take effect in the same step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 121 | Instruction word, sampled once per step |
| esc_limit_i | input | 26 | Escape magnitude limit (bits 25:0 of a non-negative value) |
| step_sync_o | output | 1 | High in the first cycle of each step |
| neg_go_o | output | 1 | Negate slot enabled this step |
| neg_op_o | output | 27 | Negate operand |
| neg_res_i | input | 27 | Negate unit result |
| add_go_o | output | 1 | Add slot enabled this step |
| add_a_o | output | 27 | Add first operand |
| add_b_o | output | 27 | Add second operand |
| add_res_i | input | 27 | Add unit result |
| mul_go_o | output | 1 | Multiply slot enabled this step |
| mul_a_o | output | 27 | Multiply first operand |
| mul_b_o | output | 27 | Multiply second operand |
| mul_res_i | input | 27 | Multiply unit result |
| z_re_o | output | 27 | Contents of register 0 |
| z_im_o | output | 27 | Contents of register 1 |
| done_o | output | 1 | Sticky escape flag |

## Verification
Two things can happen at the same write-back edge: the escape comparison on register 2, and the commits of the other slots into registers 0 and 1 and the general registers. The bench provokes this with words that send an add result into register 2 while the load and negate slots update Z. It then judges both effects on the next first-of-step cycle against a bench model of the file and the escape rule. A second same-step collision, a register read as a source while another slot overwrites it, is forced in both directed and random words. The operands seen by the pipes are compared with the pre-step model values.

// File: rtl/vrf_pkg.sv
package vrf_pkg;
  localparam int unsigned FP_W_DEF = 27;
  localparam int unsigned RA_W_DEF = 10;

  // write-port indices (order is also the commit order inside one edge)
  localparam int unsigned WP_LD  = 0;
  localparam int unsigned WP_NEG = 1;
  localparam int unsigned WP_ADD = 2;
  localparam int unsigned WP_MUL = 3;
  localparam int unsigned N_WR   = 4;

  // read-port indices
  localparam int unsigned RP_NEG = 0;
  localparam int unsigned RP_AA  = 1;
  localparam int unsigned RP_AB  = 2;
  localparam int unsigned RP_MA  = 3;
  localparam int unsigned RP_MB  = 4;
  localparam int unsigned N_RD   = 5;

  // load slot: en + imm + dst; negate: en + 2 addr; add/mul: en + 3 addr each
  function automatic int unsigned word_width(int unsigned fp_w, int unsigned ra_w);
    return 9 * ra_w + fp_w + 4;
  endfunction
endpackage

// File: rtl/vrf_step_seq.sv
module vrf_step_seq #(
  parameter int unsigned HOLD = 4
) (
  input  logic clk,
  input  logic rst,
  output logic step_sync_o,
  output logic cap_en_o,
  output logic opr_en_o,
  output logic wb_en_o
);
  // HOLD must be at least 3: capture, operand read, write-back phases
  localparam int unsigned PH_W = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(HOLD - 1);
  localparam logic [PH_W-1:0] PH_OPR  = PH_W'(1);

  logic [PH_W-1:0] ph_q;
  logic            sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= '0;
      sync_q <= 1'b1;
    end else begin
      ph_q   <= (ph_q == PH_LAST) ? '0 : ph_q + PH_W'(1);
      sync_q <= (ph_q == PH_LAST);
    end
  end

  assign step_sync_o = sync_q;
  assign cap_en_o    = (ph_q == '0);
  assign opr_en_o    = (ph_q == PH_OPR);
  assign wb_en_o     = (ph_q == PH_LAST);

  assert_sync_single_R1: assert property (@(posedge clk) disable iff (rst)
    step_sync_o |=> !step_sync_o);
  assert_wb_then_sync_R1: assert property (@(posedge clk) disable iff (rst)
    wb_en_o |=> step_sync_o);
endmodule

// File: rtl/vrf_decode.sv
module vrf_decode
  import vrf_pkg::*;
#(
  parameter int unsigned FP_W = FP_W_DEF,
  parameter int unsigned RA_W = RA_W_DEF,
  localparam int unsigned WORD_W = word_width(FP_W, RA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              ld_en_o,
  output logic [FP_W-1:0]   ld_imm_o,
  output logic [RA_W-1:0]   ld_dst_o,
  output logic              neg_en_o,
  output logic [RA_W-1:0]   neg_src_o,
  output logic [RA_W-1:0]   neg_dst_o,
  output logic              add_en_o,
  output logic [RA_W-1:0]   add_sa_o,
  output logic [RA_W-1:0]   add_sb_o,
  output logic [RA_W-1:0]   add_dst_o,
  output logic              mul_en_o,
  output logic [RA_W-1:0]   mul_sa_o,
  output logic [RA_W-1:0]   mul_sb_o,
  output logic [RA_W-1:0]   mul_dst_o
);
  // field offsets, built upward from bit 0
  localparam int unsigned MUL_DST = 0;
  localparam int unsigned MUL_SB  = RA_W;
  localparam int unsigned MUL_SA  = 2 * RA_W;
  localparam int unsigned MUL_EN  = 3 * RA_W;
  localparam int unsigned ADD_DST = MUL_EN + 1;
  localparam int unsigned ADD_SB  = ADD_DST + RA_W;
  localparam int unsigned ADD_SA  = ADD_SB + RA_W;
  localparam int unsigned ADD_EN  = ADD_SA + RA_W;
  localparam int unsigned NEG_DST = ADD_EN + 1;
  localparam int unsigned NEG_SRC = NEG_DST + RA_W;
  localparam int unsigned NEG_EN  = NEG_SRC + RA_W;
  localparam int unsigned LD_DST  = NEG_EN + 1;
  localparam int unsigned LD_IMM  = LD_DST + RA_W;
  localparam int unsigned LD_EN   = LD_IMM + FP_W;

  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst)           word_q <= '0;
    else if (cap_en_i) word_q <= word_i;
  end

  assign ld_en_o   = word_q[LD_EN];
  assign ld_imm_o  = word_q[LD_IMM +: FP_W];
  assign ld_dst_o  = word_q[LD_DST +: RA_W];
  assign neg_en_o  = word_q[NEG_EN];
  assign neg_src_o = word_q[NEG_SRC +: RA_W];
  assign neg_dst_o = word_q[NEG_DST +: RA_W];
  assign add_en_o  = word_q[ADD_EN];
  assign add_sa_o  = word_q[ADD_SA +: RA_W];
  assign add_sb_o  = word_q[ADD_SB +: RA_W];
  assign add_dst_o = word_q[ADD_DST +: RA_W];
  assign mul_en_o  = word_q[MUL_EN];
  assign mul_sa_o  = word_q[MUL_SA +: RA_W];
  assign mul_sb_o  = word_q[MUL_SB +: RA_W];
  assign mul_dst_o = word_q[MUL_DST +: RA_W];

  assert_word_held_R1: assert property (@(posedge clk) disable iff (rst)
    !cap_en_i |=> $stable(word_q));
endmodule

// File: rtl/vrf_regfile.sv
module vrf_regfile
  import vrf_pkg::*;
#(
  parameter int unsigned FP_W  = FP_W_DEF,
  parameter int unsigned RA_W  = RA_W_DEF,
  parameter int unsigned NRD   = N_RD,
  parameter int unsigned NWR   = N_WR,
  localparam int unsigned DEPTH = 1 << RA_W
) (
  input  logic                       clk,
  input  logic [NRD-1:0][RA_W-1:0]   rd_addr_i,
  output logic [NRD-1:0][FP_W-1:0]   rd_data_o,
  input  logic [NWR-1:0]             we_i,
  input  logic [NWR-1:0][RA_W-1:0]   wa_i,
  input  logic [NWR-1:0][FP_W-1:0]   wd_i,
  output logic [FP_W-1:0]            z_re_o,
  output logic [FP_W-1:0]            z_im_o
);
  // contents deliberately not reset: Z must survive a reset of the step logic
  logic [FP_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    for (int p = 0; p < int'(NWR); p++) begin
      if (we_i[p]) mem_q[wa_i[p]] <= wd_i[p];
    end
  end

  for (genvar g = 0; g < int'(NRD); g++) begin : g_rd
    assign rd_data_o[g] = mem_q[rd_addr_i[g]];
  end

  assign z_re_o = mem_q[0];
  assign z_im_o = mem_q[1];
endmodule

// File: rtl/vrf_escape.sv
module vrf_escape
  import vrf_pkg::*;
#(
  parameter int unsigned FP_W     = FP_W_DEF,
  parameter int unsigned RA_W     = RA_W_DEF,
  parameter int unsigned NWR      = N_WR,
  parameter int unsigned ESC_ADDR = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wb_en_i,
  input  logic [NWR-1:0]           we_i,
  input  logic [NWR-1:0][RA_W-1:0] wa_i,
  input  logic [NWR-1:0][FP_W-1:0] wd_i,
  input  logic [FP_W-2:0]          limit_i,
  output logic                     done_o
);
  logic hit;
  logic done_q;

  always_comb begin
    hit = 1'b0;
    for (int p = 0; p < int'(NWR); p++) begin
      if (we_i[p] && (wa_i[p] == RA_W'(ESC_ADDR)) && !wd_i[p][FP_W-1]
          && (wd_i[p][FP_W-2:0] > limit_i))
        hit = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                done_q <= 1'b0;
    else if (wb_en_i && hit) done_q <= 1'b1;
  end

  assign done_o = done_q;

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    done_q |=> done_q);
  assert_done_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> $past(wb_en_i));
  assert_done_clear_R9: assert property (@(posedge clk)
    rst |=> !done_q);
endmodule

// File: rtl/vliw_issue_rf.sv
module vliw_issue_rf
  import vrf_pkg::*;
#(
  parameter int unsigned FP_W     = FP_W_DEF,
  parameter int unsigned RA_W     = RA_W_DEF,
  parameter int unsigned HOLD     = 4,
  parameter int unsigned ESC_ADDR = 2,
  localparam int unsigned WORD_W  = word_width(FP_W, RA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] instr_i,
  input  logic [FP_W-2:0]   esc_limit_i,
  output logic              step_sync_o,
  output logic              neg_go_o,
  output logic [FP_W-1:0]   neg_op_o,
  input  logic [FP_W-1:0]   neg_res_i,
  output logic              add_go_o,
  output logic [FP_W-1:0]   add_a_o,
  output logic [FP_W-1:0]   add_b_o,
  input  logic [FP_W-1:0]   add_res_i,
  output logic              mul_go_o,
  output logic [FP_W-1:0]   mul_a_o,
  output logic [FP_W-1:0]   mul_b_o,
  input  logic [FP_W-1:0]   mul_res_i,
  output logic [FP_W-1:0]   z_re_o,
  output logic [FP_W-1:0]   z_im_o,
  output logic              done_o
);
  logic cap_en, opr_en, wb_en;

  logic            ld_en, neg_en, add_en, mul_en;
  logic [FP_W-1:0] ld_imm;
  logic [RA_W-1:0] ld_dst, neg_src, neg_dst;
  logic [RA_W-1:0] add_sa, add_sb, add_dst, mul_sa, mul_sb, mul_dst;

  logic [N_RD-1:0][RA_W-1:0] rd_addr;
  logic [N_RD-1:0][FP_W-1:0] rd_data;
  logic [N_WR-1:0]           we;
  logic [N_WR-1:0][RA_W-1:0] wa;
  logic [N_WR-1:0][FP_W-1:0] wd;

  vrf_step_seq #(.HOLD(HOLD)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .step_sync_o (step_sync_o),
    .cap_en_o    (cap_en),
    .opr_en_o    (opr_en),
    .wb_en_o     (wb_en)
  );

  vrf_decode #(.FP_W(FP_W), .RA_W(RA_W)) u_dec (
    .clk       (clk),
    .rst       (rst),
    .cap_en_i  (cap_en),
    .word_i    (instr_i),
    .ld_en_o   (ld_en),
    .ld_imm_o  (ld_imm),
    .ld_dst_o  (ld_dst),
    .neg_en_o  (neg_en),
    .neg_src_o (neg_src),
    .neg_dst_o (neg_dst),
    .add_en_o  (add_en),
    .add_sa_o  (add_sa),
    .add_sb_o  (add_sb),
    .add_dst_o (add_dst),
    .mul_en_o  (mul_en),
    .mul_sa_o  (mul_sa),
    .mul_sb_o  (mul_sb),
    .mul_dst_o (mul_dst)
  );

  assign rd_addr[RP_NEG] = neg_src;
  assign rd_addr[RP_AA]  = add_sa;
  assign rd_addr[RP_AB]  = add_sb;
  assign rd_addr[RP_MA]  = mul_sa;
  assign rd_addr[RP_MB]  = mul_sb;

  // write ports commit only on the last cycle of the step
  assign we[WP_LD]  = wb_en & ld_en;
  assign wa[WP_LD]  = ld_dst;
  assign wd[WP_LD]  = ld_imm;
  assign we[WP_NEG] = wb_en & neg_en;
  assign wa[WP_NEG] = neg_dst;
  assign wd[WP_NEG] = neg_res_i;
  assign we[WP_ADD] = wb_en & add_en;
  assign wa[WP_ADD] = add_dst;
  assign wd[WP_ADD] = add_res_i;
  assign we[WP_MUL] = wb_en & mul_en;
  assign wa[WP_MUL] = mul_dst;
  assign wd[WP_MUL] = mul_res_i;

  vrf_regfile #(.FP_W(FP_W), .RA_W(RA_W), .NRD(N_RD), .NWR(N_WR)) u_rf (
    .clk       (clk),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .we_i      (we),
    .wa_i      (wa),
    .wd_i      (wd),
    .z_re_o    (z_re_o),
    .z_im_o    (z_im_o)
  );

  // operand registers: loaded once per step, before any write-back of that step
  logic            neg_go_q, add_go_q, mul_go_q;
  logic [FP_W-1:0] neg_op_q, add_a_q, add_b_q, mul_a_q, mul_b_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      neg_go_q <= 1'b0;
      add_go_q <= 1'b0;
      mul_go_q <= 1'b0;
      neg_op_q <= '0;
      add_a_q  <= '0;
      add_b_q  <= '0;
      mul_a_q  <= '0;
      mul_b_q  <= '0;
    end else if (opr_en) begin
      neg_go_q <= neg_en;
      add_go_q <= add_en;
      mul_go_q <= mul_en;
      neg_op_q <= rd_data[RP_NEG];
      add_a_q  <= rd_data[RP_AA];
      add_b_q  <= rd_data[RP_AB];
      mul_a_q  <= rd_data[RP_MA];
      mul_b_q  <= rd_data[RP_MB];
    end
  end

  assign neg_go_o = neg_go_q;
  assign add_go_o = add_go_q;
  assign mul_go_o = mul_go_q;
  assign neg_op_o = neg_op_q;
  assign add_a_o  = add_a_q;
  assign add_b_o  = add_b_q;
  assign mul_a_o  = mul_a_q;
  assign mul_b_o  = mul_b_q;

  vrf_escape #(.FP_W(FP_W), .RA_W(RA_W), .NWR(N_WR), .ESC_ADDR(ESC_ADDR)) u_esc (
    .clk     (clk),
    .rst     (rst),
    .wb_en_i (wb_en),
    .we_i    (we),
    .wa_i    (wa),
    .wd_i    (wd),
    .limit_i (esc_limit_i),
    .done_o  (done_o)
  );

  assert_opr_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !opr_en |=> $stable({neg_go_q, add_go_q, mul_go_q,
                         neg_op_q, add_a_q, add_b_q, mul_a_q, mul_b_q}));
  assert_opr_before_wb_R5: assert property (@(posedge clk) disable iff (rst)
    opr_en |-> !wb_en);
endmodule

// File: tb/vliw_issue_rf_tb_top.sv
`timescale 1ns/1ps
module vliw_issue_rf_tb_top;
  localparam int HOLD = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [120:0] instr = '0;
  logic [25:0] lim = 26'h3FFFFFF;
  logic        sync, ngo, ago, mgo, done;
  logic [26:0] nop_v, aa, ab, ma, mb, zre, zim;
  logic [26:0] nres, ares = '0, mres = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [26:0] mdl [16];
  logic        dn_m = 1'b0;

  always #2.5 clk = ~clk;

  vliw_issue_rf dut_i (
    .clk(clk), .rst(rst), .instr_i(instr), .esc_limit_i(lim),
    .step_sync_o(sync),
    .neg_go_o(ngo), .neg_op_o(nop_v), .neg_res_i(nres),
    .add_go_o(ago), .add_a_o(aa), .add_b_o(ab), .add_res_i(ares),
    .mul_go_o(mgo), .mul_a_o(ma), .mul_b_o(mb), .mul_res_i(mres),
    .z_re_o(zre), .z_im_o(zim), .done_o(done)
  );

  // behavioural pipe models: negate combinational, add/mul one register stage
  assign nres = nop_v ^ 27'h4000000;
  always @(posedge clk) begin
    ares <= aa + ab;
    mres <= ma * mb;
  end

  function automatic logic [120:0] mk(
      input logic le, input logic [26:0] li, input logic [9:0] ld,
      input logic ne, input logic [9:0] ns, input logic [9:0] nd,
      input logic ae, input logic [9:0] a1, input logic [9:0] a2, input logic [9:0] ad,
      input logic me, input logic [9:0] m1, input logic [9:0] m2, input logic [9:0] md);
    return {le, li, ld, ne, ns, nd, ae, a1, a2, ad, me, m1, m2, md};
  endfunction

  function automatic logic escapes(input logic [26:0] v, input logic [25:0] l);
    return !v[26] && (v[25:0] > l);
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one full step; assumes caller is at a negedge; ends at the negedge of the next step's first cycle
  task automatic run_step(input logic [120:0] w, input string ztag);
    logic le = w[120];
    logic [26:0] li = w[119:93];
    logic [3:0] ld = w[86:83];
    logic ne = w[82];
    logic [3:0] ns = w[75:72];
    logic [3:0] nd = w[65:62];
    logic ae = w[61];
    logic [3:0] a1 = w[54:51];
    logic [3:0] a2 = w[44:41];
    logic [3:0] ad = w[34:31];
    logic me = w[30];
    logic [3:0] m1 = w[23:20];
    logic [3:0] m2 = w[13:10];
    logic [3:0] md = w[3:0];
    logic [26:0] vn, va, vm;
    while (!sync) @(negedge clk);
    instr = w;
    @(posedge clk);
    #1 instr = {25'($urandom()), $urandom(), $urandom(), $urandom()};
    @(negedge clk);
    @(negedge clk);
    // R3 / R5: operands reflect pre-step contents
    check("R3", "neg_go", 32'(ngo), 32'(ne));
    check("R3", "add_go", 32'(ago), 32'(ae));
    check("R3", "mul_go", 32'(mgo), 32'(me));
    if (ne) check("R5", "neg_op", 32'(nop_v), 32'(mdl[ns]));
    if (ae) begin
      check("R5", "add_a", 32'(aa), 32'(mdl[a1]));
      check("R5", "add_b", 32'(ab), 32'(mdl[a2]));
    end
    if (me) begin
      check("R5", "mul_a", 32'(ma), 32'(mdl[m1]));
      check("R5", "mul_b", 32'(mb), 32'(mdl[m2]));
    end
    vn = mdl[ns] ^ 27'h4000000;
    va = mdl[a1] + mdl[a2];
    vm = mdl[m1] * mdl[m2];
    for (int k = 2; k < HOLD; k++) @(negedge clk);
    if (le) begin mdl[ld] = li; if (ld == 4'd2 && escapes(li, lim)) dn_m = 1'b1; end
    if (ne) begin mdl[nd] = vn; if (nd == 4'd2 && escapes(vn, lim)) dn_m = 1'b1; end
    if (ae) begin mdl[ad] = va; if (ad == 4'd2 && escapes(va, lim)) dn_m = 1'b1; end
    if (me) begin mdl[md] = vm; if (md == 4'd2 && escapes(vm, lim)) dn_m = 1'b1; end
    check(ztag, "z_re", 32'(zre), 32'(mdl[0]));
    check(ztag, "z_im", 32'(zim), 32'(mdl[1]));
    check("R8", "done", 32'(done), 32'(dn_m));
    check("R1", "step_sync", 32'(sync), 32'd1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    dn_m = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state R9, cadence R1
    check("R9", "done after reset", 32'(done), 32'd0);
    check("R9", "go flags after reset", 32'({ngo, ago, mgo}), 32'd0);
    check("R1", "sync at step start", 32'(sync), 32'd1);
    for (int k = 1; k <= HOLD; k++) begin
      @(negedge clk);
      check("R1", "sync cadence", 32'(sync), 32'(k == HOLD));
    end

    // R2: fill registers 0..15 with loads; register 2 gets a negative value
    for (int r = 0; r < 16; r++) begin
      logic [26:0] v;
      v = 27'($urandom());
      if (r == 2) v[26] = 1'b1;
      run_step(mk(1'b1, v, 10'(r), 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0), "R2");
    end

    // R4: all-zero word and a word with fields set but enables clear
    run_step('0, "R4");
    run_step(mk(1'b0, 27'h1234567, 10'd0, 1'b0, 10'd3, 10'd1, 1'b0, 10'd4, 10'd5, 10'd0,
                1'b0, 10'd6, 10'd7, 10'd1), "R4");
    // read back the registers the disabled word named as destinations
    run_step(mk(0, 0, 0, 1'b1, 10'd0, 10'd12, 1'b1, 10'd1, 10'd1, 10'd13, 0, 0, 0, 0), "R4");

    // R5: slots overwrite registers that are sources in the same step
    run_step(mk(1'b1, 27'h0ABCDEF, 10'd5, 1'b1, 10'd5, 10'd6, 1'b1, 10'd5, 10'd6, 10'd7,
                1'b1, 10'd6, 10'd7, 10'd8), "R5");
    run_step(mk(0, 0, 0, 1'b1, 10'd5, 10'd9, 1'b1, 10'd6, 10'd7, 10'd10, 1'b1, 10'd8, 10'd5, 10'd11), "R5");

    // R10: four slots, four distinct destinations including both Z registers
    run_step(mk(1'b1, 27'h0000123, 10'd0, 1'b1, 10'd3, 10'd1, 1'b1, 10'd4, 10'd5, 10'd8,
                1'b1, 10'd9, 10'd10, 10'd11), "R10");
    check("R10", "z_re from load", 32'(zre), 32'h0000123);
    run_step(mk(0, 0, 0, 1'b1, 10'd8, 10'd12, 1'b1, 10'd11, 10'd1, 10'd13, 0, 0, 0, 0), "R10");

    // R6: add and multiply results (one register stage) land in Z
    run_step(mk(0, 0, 0, 0, 0, 0, 1'b1, 10'd4, 10'd5, 10'd0, 1'b1, 10'd6, 10'd7, 10'd1), "R6");
    run_step(mk(0, 0, 0, 1'b1, 10'd0, 10'd1, 0, 0, 0, 0, 0, 0, 0, 0), "R6");

    // R8: escape rule, limit 0x100000
    lim = 26'h0100000;
    run_step(mk(1'b1, {1'b1, 26'h3FFFFFF}, 10'd2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0), "R8");
    check("R8", "negative value no escape", 32'(done), 32'd0);
    run_step(mk(1'b1, {1'b0, 26'h0100000}, 10'd2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0), "R8");
    check("R8", "equal value no escape", 32'(done), 32'd0);
    run_step(mk(1'b1, {1'b0, 26'h3FFFFFF}, 10'd3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0), "R8");
    check("R8", "other register no escape", 32'(done), 32'd0);
    run_step(mk(1'b1, 27'h0000001, 10'd14, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0), "R8");
    // add 2 + 14 -> 2 (limit + 1) while load and negate update Z in the same edge
    run_step(mk(1'b1, 27'h0000777, 10'd0, 1'b1, 10'd5, 10'd1, 1'b1, 10'd2, 10'd14, 10'd2,
                0, 0, 0, 0), "R8");
    check("R8", "escape just above limit", 32'(done), 32'd1);
    run_step(mk(1'b1, 27'h0, 10'd2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0), "R9");
    check("R9", "done sticky", 32'(done), 32'd1);

    // R9 / R7: reset clears done, keeps contents
    do_reset();
    check("R9", "done cleared", 32'(done), 32'd0);
    check("R9", "go flags cleared", 32'({ngo, ago, mgo}), 32'd0);
    check("R9", "sync restarts", 32'(sync), 32'd1);
    check("R7", "z_re kept over reset", 32'(zre), 32'(mdl[0]));
    check("R7", "z_im kept over reset", 32'(zim), 32'(mdl[1]));

    // constrained random steps
    lim = 26'h3F00000;
    for (int s = 0; s < 400; s++) begin
      logic [3:0] d0, d1, d2, d3;
      logic e0, e1, e2, e3;
      e0 = ($urandom() % 3) == 0;
      e1 = $urandom() % 2;
      e2 = $urandom() % 2;
      e3 = $urandom() % 2;
      d0 = 4'($urandom());
      do d1 = 4'($urandom()); while (d1 == d0);
      do d2 = 4'($urandom()); while (d2 == d0 || d2 == d1);
      do d3 = 4'($urandom()); while (d3 == d0 || d3 == d1 || d3 == d2);
      run_step(mk(e0, 27'($urandom()), 10'(d0),
                  e1, 10'($urandom() % 16), 10'(d1),
                  e2, 10'($urandom() % 16), 10'($urandom() % 16), 10'(d2),
                  e3, 10'($urandom() % 16), 10'($urandom() % 16), 10'(d3)), "R7");
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule